// File: doc/BRIEF.md
# Residual Block Dispatcher for Parallel Coding Lanes

This block sits between a predictor that delivers four mapped residuals every cycle and a set of coding lanes that each accept one residual per cycle. It packs the incoming residuals into a small ring of block buffers, four at a time. Once a buffer holds a complete block of J residuals, the block is handed whole to one coding lane. The lanes are served in a fixed rotating order. After a lane accepts a block, it receives the residuals of that block one per cycle, oldest first, and the final residual carries an end marker.

Each handed-over block carries a short sequence tag that increments with every dispatch. Logic further downstream can use the tag to put the coded lane outputs back into the original order. If the lane whose turn it is cannot take its block, the block waits and no other lane is served. When every buffer is occupied and nothing can leave in the current cycle, the dispatcher stops accepting input.

The block size J must be a multiple of 4. At least two buffers and at least two lanes are required.

Top module: `blkdisp_top`

## Requirements
- R1: After reset, `in_ready` is 1, every `lane_valid` bit and every `lane_start_valid` bit is 0, and `start_seq` is 0.
- R2: Input slot s of `in_data`, bits [s*W +: W], holds an older residual than slot s+1, and later accepted words hold younger residuals. Each lane emits the J residuals of its block in exactly this arrival order, and every complete block is delivered exactly once.
- R3: After a start handshake on lane i, that lane emits `lane_valid[i]`=1 on exactly J consecutive cycles starting in the next cycle, and `lane_last[i]` is 1 only on the J-th of them.
- R4: Blocks go to the lanes in rotating order 0, 1, …, NLANES-1, 0, … The k-th complete block (counting from 0) is started on lane k mod NLANES.
- R5: The sequence tag on `start_seq` during the start handshake of the k-th block equals k mod 2^SEQW.
- R6: While the lane whose turn it is holds `lane_start_ready` low or is still streaming, no block is started on any lane.
- R7: `in_ready` is 0 exactly when all NBUF buffers hold complete, undispatched blocks and no start handshake occurs in the same cycle.
- R8: A lane can accept its next block in the cycle in which it emits the last residual of its current block, so its output stream has no gap.
- R9: At most one start handshake occurs in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Four residuals offered on `in_data` |
| in_ready | output | 1 | Dispatcher can take the offered word |
| in_data | input | 4*W | Four residuals, slot 0 oldest |
| lane_start_valid | output | NLANES | Block ready for this lane |
| lane_start_ready | input | NLANES | Lane agrees to take a block |
| start_seq | output | SEQW | Sequence tag of the block being started |
| lane_valid | output | NLANES | Lane residual stream valid |
| lane_data | output | NLANES*W | Residual for lane i at bits [i*W +: W] |
| lane_last | output | NLANES | Final residual of the block on this lane |

## Verification
Every residual that goes in is a running sample index, so any swap, duplication or loss shows up as a wrong value on a lane. A continuous full-rate stream with all lanes willing shows that dispatch keeps pace with the input and that lanes reload without a gap. Input with valid gaps varies where block boundaries fall relative to the dispatch cycles. Holding the lane whose turn it is unwilling, both in one long stall and in a rotating pattern, separates a correct wait-in-turn from skipping ahead, fills the buffer ring, and checks the exact cycles in which input is refused.

// File: rtl/blkdisp_pkg.sv
package blkdisp_pkg;

  // Ring pointer advance with wrap at 'size'.
  function automatic int unsigned next_ring(int unsigned cur, int unsigned size);
    return (cur + 1 >= size) ? 0 : cur + 1;
  endfunction

  // Bit offset of an input word 'chunk' inside a block of W-bit residuals.
  function automatic int unsigned chunk_lsb(int unsigned chunk, int unsigned w);
    return chunk * 4 * w;
  endfunction

endpackage

// File: rtl/blkdisp_pool.sv
module blkdisp_pool
  import blkdisp_pkg::*;
#(
  parameter int W    = 8,
  parameter int J    = 8,
  parameter int NBUF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [4*W-1:0]   wr_data,
  input  logic             pop,
  output logic             space,
  output logic             head_full,
  output logic [J*W-1:0]   head_data
);
  localparam int CHUNKS = J / 4;
  localparam int CW     = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
  localparam int BW     = $clog2(NBUF);
  localparam int WORD   = 4 * W;

  logic [J*W-1:0] mem [NBUF];
  logic [NBUF-1:0] full;
  logic [BW-1:0]   wr_idx, rd_idx;
  logic [CW-1:0]   chunk;

  wire chunk_last = (chunk == CW'(CHUNKS - 1));
  wire blk_done   = wr_en && chunk_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= '0;
      wr_idx <= '0;
      rd_idx <= '0;
      chunk  <= '0;
    end else begin
      if (pop) begin
        full[rd_idx] <= 1'b0;
        rd_idx       <= BW'(next_ring(32'(rd_idx), NBUF));
      end
      if (blk_done) begin
        full[wr_idx] <= 1'b1;
        wr_idx       <= BW'(next_ring(32'(wr_idx), NBUF));
      end
      if (wr_en) chunk <= chunk_last ? '0 : chunk + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx][chunk_lsb(32'(chunk), W) +: WORD] <= wr_data;
  end

  assign space     = !full[wr_idx];
  assign head_full = full[rd_idx];
  assign head_data = mem[rd_idx];

  p_pop_has_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_full);
  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!full[wr_idx] || (pop && rd_idx == wr_idx)));
  p_fill_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> full[$past(wr_idx)]);

endmodule

// File: rtl/blkdisp_lane.sv
module blkdisp_lane #(
  parameter int W = 8,
  parameter int J = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [J*W-1:0] load_data,
  output logic           free,
  output logic           o_valid,
  output logic [W-1:0]   o_data,
  output logic           o_last
);
  localparam int CW = $clog2(J);

  logic [J*W-1:0] sr;
  logic [CW-1:0]  cnt;
  logic           busy;

  wire is_last = busy && (cnt == CW'(J - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (is_last) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load)      sr <= load_data;
    else if (busy) sr <= sr >> W;
  end

  assign free    = !busy || is_last;
  assign o_valid = busy;
  assign o_data  = sr[W-1:0];
  assign o_last  = is_last;

  p_load_when_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!o_valid || o_last));
  p_load_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (o_valid && cnt == '0));
  p_stream_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (o_last && !load) |=> !o_valid);

endmodule

// File: rtl/blkdisp_top.sv
module blkdisp_top
  import blkdisp_pkg::*;
#(
  parameter int W      = 8,
  parameter int J      = 8,
  parameter int NLANES = 4,
  parameter int NBUF   = 2,
  parameter int SEQW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [4*W-1:0]       in_data,
  output logic [NLANES-1:0]    lane_start_valid,
  input  logic [NLANES-1:0]    lane_start_ready,
  output logic [SEQW-1:0]      start_seq,
  output logic [NLANES-1:0]    lane_valid,
  output logic [NLANES*W-1:0]  lane_data,
  output logic [NLANES-1:0]    lane_last
);
  localparam int LW = $clog2(NLANES);

  logic [LW-1:0]     rr;
  logic [SEQW-1:0]   seq;
  logic [NLANES-1:0] lane_free;
  logic [NLANES-1:0] fire_vec;
  logic              pop, space, head_full, wr_en;
  logic [J*W-1:0]    head_data;

  always_comb begin
    for (int i = 0; i < NLANES; i++)
      lane_start_valid[i] = head_full && (rr == LW'(i)) && lane_free[i];
  end

  assign fire_vec = lane_start_valid & lane_start_ready;
  assign pop      = |fire_vec;
  assign in_ready = space || pop;
  assign wr_en    = in_valid && in_ready;
  assign start_seq = seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr  <= '0;
      seq <= '0;
    end else if (pop) begin
      rr  <= LW'(next_ring(32'(rr), NLANES));
      seq <= seq + 1'b1;
    end
  end

  blkdisp_pool #(.W(W), .J(J), .NBUF(NBUF)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (in_data),
    .pop       (pop),
    .space     (space),
    .head_full (head_full),
    .head_data (head_data)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    blkdisp_lane #(.W(W), .J(J)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (fire_vec[g]),
      .load_data (head_data),
      .free      (lane_free[g]),
      .o_valid   (lane_valid[g]),
      .o_data    (lane_data[g*W +: W]),
      .o_last    (lane_last[g])
    );
  end

  p_one_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_vec));
  p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> start_seq == $past(start_seq) + SEQW'(1));
  p_rr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> rr == LW'(next_ring(32'($past(rr)), NLANES)));
  p_wait_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (head_full && !lane_start_ready[rr]) |=> (head_full && $stable(rr)));

endmodule

// File: tb/blkdisp_top_bench.sv
module blkdisp_top_bench;
  timeunit 1ns; timeprecision 1ns;

  localparam int W = 8, J = 8, NL = 4, NBUF = 2, SEQW = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [4*W-1:0] in_data = '0;
  logic [NL-1:0] lane_start_ready = '1;
  logic in_ready;
  logic [NL-1:0] lane_start_valid, lane_valid, lane_last;
  logic [SEQW-1:0] start_seq;
  logic [NL*W-1:0] lane_data;

  always #10 clk = ~clk;

  blkdisp_top #(.W(W), .J(J), .NLANES(NL), .NBUF(NBUF), .SEQW(SEQW)) u_blkdisp_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .lane_start_valid(lane_start_valid),
    .lane_start_ready(lane_start_ready), .start_seq(start_seq),
    .lane_valid(lane_valid), .lane_data(lane_data), .lane_last(lane_last));

  int n_chk = 0, n_bad = 0;
  int accepted = 0, dispatched = 0, b2b = 0, hold_fires = 0;
  bit holding = 0, done = 0;
  int act [NL], cnt [NL], base [NL];

  task automatic check(bit ok, string req, int actual, int expected);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // One cycle: drive at negedge, observe settled outputs, account for the coming edge.
  task automatic step(bit v, logic [NL-1:0] rmask);
    logic [NL-1:0] fire;
    int waiting;
    @(negedge clk);
    in_valid = v;
    for (int s = 0; s < 4; s++) in_data[s*W +: W] = W'(accepted + s);
    lane_start_ready = rmask;
    #1;
    fire = lane_start_valid & lane_start_ready;
    // R7: refuse input exactly when the ring is full of waiting blocks and nothing leaves
    waiting = accepted / J - dispatched;
    check(in_ready == ((waiting < NBUF) || (fire != 0)), "R7", in_ready,
          (waiting < NBUF) || (fire != 0));
    // R9: at most one start per cycle
    check($countones(fire) <= 1, "R9", $countones(fire), 1);
    for (int i = 0; i < NL; i++) begin
      if (lane_valid[i]) begin
        check(act[i] == 1, "R3", 0, 1);
        check(lane_data[i*W +: W] == W'(base[i] + cnt[i]), "R2",
              lane_data[i*W +: W], (base[i] + cnt[i]) % 256);
        check(lane_last[i] == (cnt[i] == J - 1), "R3", lane_last[i], cnt[i] == J - 1);
        cnt[i]++;
        if (cnt[i] == J) act[i] = 0;
      end else begin
        check(act[i] == 0, "R3", 0, act[i]);
      end
    end
    for (int i = 0; i < NL; i++) begin
      if (fire[i]) begin
        if (holding) hold_fires++;
        check(i == dispatched % NL, "R4", i, dispatched % NL);
        check(start_seq == SEQW'(dispatched), "R5", start_seq, dispatched % 8);
        if (lane_valid[i] && lane_last[i]) b2b++;
        act[i] = 1; cnt[i] = 0; base[i] = dispatched * J;
        dispatched++;
      end
    end
    if (v && in_ready) accepted += 4;
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin act[i] = 0; cnt[i] = 0; base[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(in_ready == 1, "R1", in_ready, 1);
    check(lane_valid == 0, "R1", lane_valid, 0);
    check(lane_start_valid == 0, "R1", lane_start_valid, 0);
    check(start_seq == 0, "R1", start_seq, 0);
    @(negedge clk); rst_n = 1;

    // Phase A: full rate, all lanes willing (R2..R5, R8; R7 expects ready throughout)
    for (int c = 0; c < 40; c++) step(1, '1);

    // Phase B: input with gaps
    for (int c = 0; c < 60; c++) step((c % 3) != 0 && (c % 7) != 5, '1);
    while (accepted % J != 0) step(1, '1);

    // Phase C: long stall on the lane whose turn it is (R6, R7)
    begin
      logic [NL-1:0] m;
      m = '1;
      m[dispatched % NL] = 1'b0;
      holding = 1;
      for (int c = 0; c < 14; c++) step(1, m);
      holding = 0;
      check(hold_fires == 0, "R6", hold_fires, 0);
      check(in_ready == 0, "R7", in_ready, 0);
    end
    for (int c = 0; c < 30; c++) step(1, '1);

    // Phase D: rotating unwilling lane
    for (int c = 0; c < 80; c++) begin
      logic [NL-1:0] m;
      m = '1;
      m[(c / 3) % NL] = 1'b0;
      step(1, m);
    end
    while (accepted % J != 0) step(1, '1);

    // Drain
    for (int c = 0; c < 200; c++) begin
      if (dispatched == accepted / J && act[0] == 0 && act[1] == 0
          && act[2] == 0 && act[3] == 0) break;
      step(0, '1);
    end
    check(dispatched == accepted / J, "R2", dispatched, accepted / J);
    check((act[0] | act[1] | act[2] | act[3]) == 0, "R3",
          act[0] | act[1] | act[2] | act[3], 0);
    check(b2b > 0, "R8", b2b, 1);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule